// File: doc/BRIEF.md
# Sprite Attribute Table Write Port

This block takes byte writes from a processor data port and keeps a 544-byte sprite attribute store. The store has a 512-byte main table, holding two 16-bit words per sprite for 128 sprites, and a 32-byte extension table, holding two extra bits per sprite. A 9-bit word pointer selects the target. Software loads the pointer once and then streams bytes. The pointer advances by itself as the bytes arrive.

Writes to the main table go in pairs. The first byte of a pair waits in a holding register. Both bytes land together when the second byte arrives, so a half-written word never appears in the store. Extension bytes skip the holding register and land at once. The block also keeps a first-sprite index that can follow the pointer, and it pulses a change flag when a write really alters stored content. The rendering logic selects one sprite at a time and reads back its decoded fields.

The pair sequencing is a two-state machine. State `PH_LOW_WAIT` waits for the first byte of a pair. State `PH_HIGH_WAIT` waits for the second byte. It has three named transitions:
- `T_LOAD`: any state goes to `PH_LOW_WAIT` when the pointer is loaded.
- `T_FIRST`: `PH_LOW_WAIT` goes to `PH_HIGH_WAIT` on a byte write.
- `T_SECOND`: `PH_HIGH_WAIT` goes to `PH_LOW_WAIT` on a byte write, and the pointer steps.

Top module: `oam_wr_port`

## Requirements
- R1: After reset, `cur_addr` is 0, `cur_phase` is 0, `first_spr` is 0 and `chg_pulse` is 0. Every stored byte is 0, so every decoded field of every sprite reads 0.
- R2: A cycle with `addr_ld` high copies `addr_val` into the pointer and sets the phase to 0 (transition `T_LOAD`). A write strobe in the same cycle is dropped: it stores nothing and raises no `chg_pulse`.
- R3: When pointer bit 8 is 0 and the phase is 0, a write only captures the byte in the holding register. The store is unchanged, `chg_pulse` stays 0, the pointer holds, and the phase becomes 1.
- R4: When pointer bit 8 is 0 and the phase is 1, a write stores the held byte at byte address 2*P and the new byte at 2*P+1, where P is the pointer. The pointer then becomes (P+1) mod 512 and the phase becomes 0, so 0x0FF steps into 0x100.
- R5: When pointer bit 8 is 1, each write stores its byte at once at extension byte index {P[3:0], phase}. Pointer bits 7:4 are ignored. The phase toggles on every write, and the pointer steps (wrapping 0x1FF to 0x000) only after a phase-1 byte.
- R6: Sprite s uses main bytes 4s to 4s+3. X position bits 7:0 come from byte 4s, and the Y position is byte 4s+1. The tile number is {byte 4s+3 bit 0, byte 4s+2}. From byte 4s+3: palette is bits 3:1, priority is bits 5:4, horizontal flip is bit 6 and vertical flip is bit 7.
- R7: Sprite s uses extension byte s>>2. Bit 2*(s mod 4) of that byte is X position bit 8, the sign bit. Bit 2*(s mod 4)+1 is the size select.
- R8: When the pointer steps while `rot_en` is high, `first_spr` becomes bits 7:1 of the new pointer. Otherwise `first_spr` holds its value.
- R9: `chg_pulse` is high for the one cycle after a storing write only if the stored bytes differ from their previous content. For a main-table pair this means either byte of the pair differs. For an extension write it means the one byte differs. In every other cycle `chg_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_ld | input | 1 | Load the word pointer from `addr_val` |
| addr_val | input | 9 | Word pointer value to load |
| wr_stb | input | 1 | Byte write strobe |
| wr_byte | input | 8 | Byte being written |
| rot_en | input | 1 | Lets the first-sprite index follow the pointer |
| spr_sel | input | 7 | Sprite whose decoded fields are shown |
| cur_addr | output | 9 | Current word pointer |
| cur_phase | output | 1 | 0 = waiting for the first byte, 1 = waiting for the second byte |
| first_spr | output | 7 | First-sprite index |
| chg_pulse | output | 1 | Stored content was altered by the previous write |
| spr_xpos | output | 9 | X position of the selected sprite, bit 8 is the sign |
| spr_ypos | output | 8 | Y position of the selected sprite |
| spr_tile | output | 9 | Tile number of the selected sprite |
| spr_pal | output | 3 | Palette of the selected sprite |
| spr_prio | output | 2 | Priority of the selected sprite |
| spr_hflip | output | 1 | Horizontal flip of the selected sprite |
| spr_vflip | output | 1 | Vertical flip of the selected sprite |
| spr_big | output | 1 | Size select of the selected sprite |

## Verification
Directed streams check the main cases one at a time:
- A lone first byte against a completed pair separates the holding register from a real commit.
- Pointer loads placed across the 0x0FF, 0x1FF and mirrored 0x1F3 boundaries separate the table selection, the wrap, and the extension index, which ignores bits 7:4.
- A load that collides with a write, and writes with `rot_en` on and off, separate the load-wins rule and the first-sprite update.

Random traffic then mixes loads, collisions and writes. About a quarter of the written bytes repeat the stored value, so changed and unchanged writes can be told apart. A full decode of all 128 sprites at the end exposes any misplaced byte or bit.

// File: rtl/oam_wr_pkg.sv
`timescale 1ns/1ps
package oam_wr_pkg;

    // Pair sequencing phase
    typedef enum logic {
        PH_LOW_WAIT  = 1'b0,
        PH_HIGH_WAIT = 1'b1
    } phase_e;

    // Decoded view of one sprite
    typedef struct packed {
        logic [8:0] xpos;
        logic [7:0] ypos;
        logic [8:0] tile;
        logic [2:0] pal;
        logic [1:0] prio;
        logic       hflip;
        logic       vflip;
        logic       big;
    } spr_attr_t;

endpackage

// File: rtl/oam_wr_ctrl.sv
`timescale 1ns/1ps
module oam_wr_ctrl
    import oam_wr_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int EXT_BYTES = 32,
    localparam int WORD_W   = ADDR_W - 1,
    localparam int SPR_W    = ADDR_W - 2,
    localparam int EXT_IW   = $clog2(EXT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              wr_stb,
    input  logic [7:0]        wr_byte,
    input  logic              rot_en,
    output logic [ADDR_W-1:0] addr_q,
    output logic              phase_q,
    output logic [SPR_W-1:0]  first_q,
    output logic              main_we,
    output logic [WORD_W-1:0] main_waddr,
    output logic [7:0]        main_lo,
    output logic [7:0]        main_hi,
    output logic              ext_we,
    output logic [EXT_IW-1:0] ext_idx,
    output logic [7:0]        ext_data
);

    phase_e              st_q, st_d;
    logic [ADDR_W-1:0]   addr_d;
    logic [ADDR_W-1:0]   addr_inc;
    logic [7:0]          latch_q, latch_d;
    logic [SPR_W-1:0]    first_d;
    logic                in_ext;

    assign in_ext   = addr_q[ADDR_W-1];
    assign addr_inc = addr_q + ADDR_W'(1);
    assign phase_q  = (st_q == PH_HIGH_WAIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= PH_LOW_WAIT;
            addr_q  <= '0;
            latch_q <= '0;
            first_q <= '0;
        end else begin
            st_q    <= st_d;
            addr_q  <= addr_d;
            latch_q <= latch_d;
            first_q <= first_d;
        end
    end

    // Next state: T_LOAD, T_FIRST, T_SECOND
    always_comb begin
        st_d    = st_q;
        addr_d  = addr_q;
        latch_d = latch_q;
        first_d = first_q;
        if (addr_ld) begin
            st_d   = PH_LOW_WAIT;
            addr_d = addr_val;
        end else if (wr_stb) begin
            unique case (st_q)
                PH_LOW_WAIT: begin
                    st_d = PH_HIGH_WAIT;
                    if (!in_ext) begin
                        latch_d = wr_byte;
                    end
                end
                PH_HIGH_WAIT: begin
                    st_d   = PH_LOW_WAIT;
                    addr_d = addr_inc;
                    if (rot_en) begin
                        first_d = addr_inc[SPR_W:1];
                    end
                end
            endcase
        end
    end

    // Outputs toward the store
    always_comb begin
        main_we    = 1'b0;
        ext_we     = 1'b0;
        main_lo    = latch_q;
        main_hi    = wr_byte;
        ext_data   = wr_byte;
        main_waddr = addr_q[WORD_W-1:0];
        ext_idx    = {addr_q[EXT_IW-2:0], phase_q};
        if (!addr_ld && wr_stb) begin
            unique case (st_q)
                PH_LOW_WAIT: begin
                    ext_we = in_ext;
                end
                PH_HIGH_WAIT: begin
                    main_we = !in_ext;
                    ext_we  = in_ext;
                end
            endcase
        end
    end

    // R2: a load sets the pointer and clears the phase
    a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ld |=> (st_q == PH_LOW_WAIT && addr_q == $past(addr_val)));

    // R3: a first byte moves the phase but not the pointer
    a_r3_first_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_ld && wr_stb && st_q == PH_LOW_WAIT)
            |=> (st_q == PH_HIGH_WAIT && addr_q == $past(addr_q)));

    // R4: a second byte steps the pointer by one
    a_r4_second_byte_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_ld && wr_stb && st_q == PH_HIGH_WAIT)
            |=> (st_q == PH_LOW_WAIT && addr_q == ADDR_W'($past(addr_q) + 1'b1)));

    // R4: with no load and no write, the pointer and phase stay put
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_ld && !wr_stb) |=> ($stable(addr_q) && $stable(st_q)));

    // R5: a write never targets both tables
    a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_we, ext_we}));

    // R8: the first-sprite index follows a stepped pointer when rotation is on
    a_r8_first_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_ld && wr_stb && st_q == PH_HIGH_WAIT && rot_en)
            |=> (first_q == addr_q[SPR_W:1]));

    // R8: otherwise the first-sprite index holds
    a_r8_first_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(!addr_ld && wr_stb && st_q == PH_HIGH_WAIT && rot_en) |=> $stable(first_q));

endmodule

// File: rtl/oam_store.sv
`timescale 1ns/1ps
module oam_store #(
    parameter int ADDR_W    = 9,
    parameter int EXT_BYTES = 32,
    localparam int MAIN_BYTES = 2 ** ADDR_W,
    localparam int WORD_W     = ADDR_W - 1,
    localparam int SPR_W      = ADDR_W - 2,
    localparam int EXT_IW     = $clog2(EXT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_we,
    input  logic [WORD_W-1:0] main_waddr,
    input  logic [7:0]        main_lo,
    input  logic [7:0]        main_hi,
    input  logic              ext_we,
    input  logic [EXT_IW-1:0] ext_idx,
    input  logic [7:0]        ext_data,
    input  logic [SPR_W-1:0]  rd_spr,
    output logic              chg_q,
    output logic [7:0]        rd_b0,
    output logic [7:0]        rd_b1,
    output logic [7:0]        rd_b2,
    output logic [7:0]        rd_b3,
    output logic [7:0]        rd_ext
);

    logic [7:0] main_mem [MAIN_BYTES];
    logic [7:0] ext_mem  [EXT_BYTES];
    logic       main_diff;
    logic       ext_diff;

    assign main_diff = (main_mem[{main_waddr, 1'b0}] != main_lo) ||
                       (main_mem[{main_waddr, 1'b1}] != main_hi);
    assign ext_diff  = (ext_mem[ext_idx] != ext_data);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAIN_BYTES; i++) main_mem[i] <= '0;
            for (int j = 0; j < EXT_BYTES; j++)  ext_mem[j]  <= '0;
            chg_q <= 1'b0;
        end else begin
            if (main_we) begin
                main_mem[{main_waddr, 1'b0}] <= main_lo;
                main_mem[{main_waddr, 1'b1}] <= main_hi;
            end
            if (ext_we) begin
                ext_mem[ext_idx] <= ext_data;
            end
            chg_q <= (main_we && main_diff) || (ext_we && ext_diff);
        end
    end

    assign rd_b0  = main_mem[{rd_spr, 2'b00}];
    assign rd_b1  = main_mem[{rd_spr, 2'b01}];
    assign rd_b2  = main_mem[{rd_spr, 2'b10}];
    assign rd_b3  = main_mem[{rd_spr, 2'b11}];
    assign rd_ext = ext_mem[rd_spr[SPR_W-1:2]];

    // R9: no storing write, no change pulse
    a_r9_quiet_without_store: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_we || ext_we) |=> !chg_q);

    // R9: the pulse lasts one cycle unless another storing write follows
    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_q && !main_we && !ext_we) |=> !chg_q);

endmodule

// File: rtl/oam_decode.sv
`timescale 1ns/1ps
module oam_decode
    import oam_wr_pkg::*;
(
    input  logic [7:0] b0,
    input  logic [7:0] b1,
    input  logic [7:0] b2,
    input  logic [7:0] b3,
    input  logic [7:0] ext_b,
    input  logic [1:0] slot,
    output spr_attr_t  attr
);

    logic [3:0] x8_s;
    logic [3:0] big_s;

    // Each extension byte feeds four sprites, two bits apiece
    for (genvar k = 0; k < 4; k++) begin : g_slot
        assign x8_s[k]  = ext_b[2*k];
        assign big_s[k] = ext_b[2*k+1];
    end

    always_comb begin
        attr.xpos  = {x8_s[slot], b0};
        attr.ypos  = b1;
        attr.tile  = {b3[0], b2};
        attr.pal   = b3[3:1];
        attr.prio  = b3[5:4];
        attr.hflip = b3[6];
        attr.vflip = b3[7];
        attr.big   = big_s[slot];
    end

endmodule

// File: rtl/oam_wr_port.sv
`timescale 1ns/1ps
module oam_wr_port
    import oam_wr_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int EXT_BYTES = 32,
    localparam int WORD_W   = ADDR_W - 1,
    localparam int SPR_W    = ADDR_W - 2,
    localparam int EXT_IW   = $clog2(EXT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              wr_stb,
    input  logic [7:0]        wr_byte,
    input  logic              rot_en,
    input  logic [SPR_W-1:0]  spr_sel,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_phase,
    output logic [SPR_W-1:0]  first_spr,
    output logic              chg_pulse,
    output logic [8:0]        spr_xpos,
    output logic [7:0]        spr_ypos,
    output logic [8:0]        spr_tile,
    output logic [2:0]        spr_pal,
    output logic [1:0]        spr_prio,
    output logic              spr_hflip,
    output logic              spr_vflip,
    output logic              spr_big
);

    logic              main_we;
    logic [WORD_W-1:0] main_waddr;
    logic [7:0]        main_lo;
    logic [7:0]        main_hi;
    logic              ext_we;
    logic [EXT_IW-1:0] ext_idx;
    logic [7:0]        ext_data;
    logic [7:0]        rd_b0, rd_b1, rd_b2, rd_b3, rd_ext;
    spr_attr_t         attr;

    oam_wr_ctrl #(.ADDR_W(ADDR_W), .EXT_BYTES(EXT_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_ld    (addr_ld),
        .addr_val   (addr_val),
        .wr_stb     (wr_stb),
        .wr_byte    (wr_byte),
        .rot_en     (rot_en),
        .addr_q     (cur_addr),
        .phase_q    (cur_phase),
        .first_q    (first_spr),
        .main_we    (main_we),
        .main_waddr (main_waddr),
        .main_lo    (main_lo),
        .main_hi    (main_hi),
        .ext_we     (ext_we),
        .ext_idx    (ext_idx),
        .ext_data   (ext_data)
    );

    oam_store #(.ADDR_W(ADDR_W), .EXT_BYTES(EXT_BYTES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .main_we    (main_we),
        .main_waddr (main_waddr),
        .main_lo    (main_lo),
        .main_hi    (main_hi),
        .ext_we     (ext_we),
        .ext_idx    (ext_idx),
        .ext_data   (ext_data),
        .rd_spr     (spr_sel),
        .chg_q      (chg_pulse),
        .rd_b0      (rd_b0),
        .rd_b1      (rd_b1),
        .rd_b2      (rd_b2),
        .rd_b3      (rd_b3),
        .rd_ext     (rd_ext)
    );

    oam_decode u_dec (
        .b0    (rd_b0),
        .b1    (rd_b1),
        .b2    (rd_b2),
        .b3    (rd_b3),
        .ext_b (rd_ext),
        .slot  (spr_sel[1:0]),
        .attr  (attr)
    );

    assign spr_xpos  = attr.xpos;
    assign spr_ypos  = attr.ypos;
    assign spr_tile  = attr.tile;
    assign spr_pal   = attr.pal;
    assign spr_prio  = attr.prio;
    assign spr_hflip = attr.hflip;
    assign spr_vflip = attr.vflip;
    assign spr_big   = attr.big;

    // R1: out of reset the port is idle
    a_r1_no_pulse_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !chg_pulse);

endmodule

// File: tb/oam_wr_port_tb_top.sv
`timescale 1ns/1ps
module oam_wr_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_ld = 1'b0;
    logic [8:0] addr_val = '0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       rot_en = 1'b0;
    logic [6:0] spr_sel = '0;
    logic [8:0] cur_addr;
    logic       cur_phase;
    logic [6:0] first_spr;
    logic       chg_pulse;
    logic [8:0] spr_xpos;
    logic [7:0] spr_ypos;
    logic [8:0] spr_tile;
    logic [2:0] spr_pal;
    logic [1:0] spr_prio;
    logic       spr_hflip;
    logic       spr_vflip;
    logic       spr_big;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [7:0] m_main [512];
    logic [7:0] m_ext  [32];
    logic [8:0] m_addr;
    logic       m_ph;
    logic [7:0] m_latch;
    logic [6:0] m_first;
    logic       m_chg;

    always #4 clk = ~clk;

    oam_wr_port dut_i (
        .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_val(addr_val),
        .wr_stb(wr_stb), .wr_byte(wr_byte), .rot_en(rot_en), .spr_sel(spr_sel),
        .cur_addr(cur_addr), .cur_phase(cur_phase), .first_spr(first_spr),
        .chg_pulse(chg_pulse), .spr_xpos(spr_xpos), .spr_ypos(spr_ypos),
        .spr_tile(spr_tile), .spr_pal(spr_pal), .spr_prio(spr_prio),
        .spr_hflip(spr_hflip), .spr_vflip(spr_vflip), .spr_big(spr_big)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_write(input logic [7:0] d, input logic rot);
        int idx;
        m_chg = 1'b0;
        if (!m_addr[8]) begin
            if (!m_ph) begin
                m_latch = d;
                m_ph = 1'b1;
            end else begin
                if (m_main[2*m_addr] != m_latch || m_main[2*m_addr+1] != d) m_chg = 1'b1;
                m_main[2*m_addr]   = m_latch;
                m_main[2*m_addr+1] = d;
                m_ph = 1'b0;
                m_addr = m_addr + 9'd1;
                if (rot) m_first = m_addr[7:1];
            end
        end else begin
            idx = {m_addr[3:0], m_ph};
            if (m_ext[idx] != d) m_chg = 1'b1;
            m_ext[idx] = d;
            if (m_ph) begin
                m_ph = 1'b0;
                m_addr = m_addr + 9'd1;
                if (rot) m_first = m_addr[7:1];
            end else begin
                m_ph = 1'b1;
            end
        end
    endtask

    task automatic check_state(input string tag);
        chk(tag, "cur_addr", cur_addr, m_addr);
        chk(tag, "cur_phase", cur_phase, m_ph);
        chk(tag, "first_spr", first_spr, m_first);
        chk({tag, "/R9"}, "chg_pulse", chg_pulse, m_chg);
    endtask

    task automatic check_spr(input string tag, input int s);
        logic [7:0] e;
        int pos;
        e = m_ext[s >> 2];
        pos = 2 * (s % 4);
        spr_sel = 7'(s);
        #1;
        chk({tag, "/R7"}, $sformatf("xpos[%0d]", s), spr_xpos, {e[pos], m_main[4*s]});
        chk({tag, "/R6"}, $sformatf("ypos[%0d]", s), spr_ypos, m_main[4*s+1]);
        chk({tag, "/R6"}, $sformatf("tile[%0d]", s), spr_tile, {m_main[4*s+3][0], m_main[4*s+2]});
        chk({tag, "/R6"}, $sformatf("pal[%0d]", s), spr_pal, m_main[4*s+3][3:1]);
        chk({tag, "/R6"}, $sformatf("prio[%0d]", s), spr_prio, m_main[4*s+3][5:4]);
        chk({tag, "/R6"}, $sformatf("hflip[%0d]", s), spr_hflip, m_main[4*s+3][6]);
        chk({tag, "/R6"}, $sformatf("vflip[%0d]", s), spr_vflip, m_main[4*s+3][7]);
        chk({tag, "/R7"}, $sformatf("big[%0d]", s), spr_big, e[pos+1]);
    endtask

    task automatic do_load(input logic [8:0] a, input string tag);
        @(negedge clk);
        addr_ld = 1'b1;
        addr_val = a;
        @(negedge clk);
        addr_ld = 1'b0;
        m_addr = a;
        m_ph = 1'b0;
        m_chg = 1'b0;
        check_state(tag);
    endtask

    task automatic do_write(input logic [7:0] d, input logic rot, input string tag);
        @(negedge clk);
        wr_stb = 1'b1;
        wr_byte = d;
        rot_en = rot;
        @(negedge clk);
        wr_stb = 1'b0;
        model_write(d, rot);
        check_state(tag);
    endtask

    task automatic do_collide(input logic [8:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        addr_ld = 1'b1;
        addr_val = a;
        wr_stb = 1'b1;
        wr_byte = d;
        @(negedge clk);
        addr_ld = 1'b0;
        wr_stb = 1'b0;
        m_addr = a;
        m_ph = 1'b0;
        m_chg = 1'b0;
        check_state(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int r;
        logic [7:0] d;
        void'($urandom(32'd24681357));
        for (int i = 0; i < 512; i++) m_main[i] = '0;
        for (int i = 0; i < 32; i++) m_ext[i] = '0;
        m_addr = '0; m_ph = 1'b0; m_latch = '0; m_first = '0; m_chg = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_state("R1");
        check_spr("R1", 5);
        check_spr("R1", 127);

        // R6: position word and attribute word of sprite 8
        do_load(9'h010, "R2");
        do_write(8'h34, 1'b0, "R3");
        do_write(8'h56, 1'b0, "R4");
        do_write(8'hA5, 1'b0, "R3");
        do_write(8'hD7, 1'b0, "R4");
        check_spr("R6", 8);

        // R3: a lone first byte leaves the store untouched
        do_load(9'h004, "R2");
        do_write(8'h77, 1'b0, "R3");
        check_spr("R3", 2);
        chk("R3", "xpos lone byte", spr_xpos, 0);
        // R2: reload clears the phase, the new first byte replaces the held one
        do_load(9'h004, "R2");
        do_write(8'h11, 1'b0, "R3");
        do_write(8'h22, 1'b0, "R4");
        check_spr("R2", 2);
        chk("R2", "xpos after reload", spr_xpos, 9'h011);

        // R9: rewriting the same pair gives no pulse
        do_load(9'h004, "R2");
        do_write(8'h11, 1'b0, "R9");
        do_write(8'h22, 1'b0, "R9");
        chk("R9", "same pair chg", chg_pulse, 0);

        // R2: collision, the load wins and the write is dropped
        do_collide(9'h006, 8'hEE, "R2");
        check_spr("R2", 3);

        // R4: 0x0FF steps into the extension table
        do_load(9'h0FF, "R4");
        do_write(8'h3C, 1'b0, "R4");
        do_write(8'h81, 1'b0, "R4");
        chk("R4", "addr after 0FF", cur_addr, 9'h100);
        check_spr("R4", 127);

        // R7: extension byte fan-out
        do_load(9'h102, "R5");
        do_write(8'h9C, 1'b0, "R5");
        chk("R5", "ext first byte no step", cur_addr, 9'h102);
        do_write(8'h63, 1'b0, "R5");
        for (int s = 16; s < 24; s++) check_spr("R7", s);

        // R5: bits 7:4 of the pointer are ignored
        do_load(9'h1F3, "R5");
        do_write(8'h5A, 1'b0, "R5");
        do_write(8'hC3, 1'b0, "R5");
        check_spr("R5", 25);
        check_spr("R5", 29);

        // R8: rotation on, then wrap 0x1FF to 0x000
        do_load(9'h0A6, "R8");
        do_write(8'h01, 1'b1, "R8");
        do_write(8'h02, 1'b1, "R8");
        chk("R8", "first after 0A6", first_spr, 7'h53);
        do_load(9'h1FF, "R8");
        do_write(8'h0F, 1'b1, "R8");
        do_write(8'hF0, 1'b1, "R8");
        chk("R4", "wrap addr", cur_addr, 0);
        chk("R8", "first after wrap", first_spr, 0);
        do_load(9'h040, "R8");
        do_write(8'h10, 1'b0, "R8");
        do_write(8'h20, 1'b0, "R8");
        chk("R8", "first held", first_spr, 0);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            r = int'($urandom % 100);
            if (r < 8) begin
                do_load(9'($urandom), "R2");
            end else if (r < 11) begin
                do_collide(9'($urandom), 8'($urandom), "R2");
            end else begin
                d = 8'($urandom);
                if (($urandom % 4) == 0) begin
                    if (!m_addr[8]) d = m_main[2*m_addr + (m_ph ? 1 : 0)];
                    else d = m_ext[{m_addr[3:0], m_ph}];
                end
                do_write(d, 1'($urandom), m_addr[8] ? "R5" : (m_ph ? "R4" : "R3"));
            end
            if ((i % 25) == 0) check_spr("R6", int'($urandom % 128));
        end
        for (int s = 0; s < 128; s++) check_spr("R6", s);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule